// File: doc/BRIEF.md
# Passive-Matrix Colour Panel Line and Frame Timer

This block produces the line and frame timing for a passive-matrix colour display. Each line is a fixed run of pixel-clock cycles: a line sync pulse, a back porch, a window of data-bus transfers with data-enable high, and a front porch. A frame is a programmed number of such lines, with no vertical porch or pulse lines. The frame sync is marked on the line sync of the first line. An AC-bias (MODE) output toggles either once per frame or every programmed number of lines, so the panel's drive polarity is reversed at a controlled rate.

The active window is counted in data-bus transfers, not pixels. For a colour panel with three bits per pixel, the transfer count is the horizontal size in bits divided by the bus width, rounded up. A 320-pixel line on an 8-line bus is 120 transfers, and the field is programmed with 119. Counting advances only on cycles where the pixel-clock enable is high. Configuration is sampled into shadow registers at each frame start, so a write made mid-frame never disturbs the frame in progress.

Top module: `stn_line_timer`

## Requirements
- R1: While `rst_n` is low, all four outputs are 0. After release they stay 0 until the first cycle with `pix_en` high. That cycle starts line 0 of a frame.
- R2: Every length field is written as the wanted count minus one. A `xfer_cnt_i` of value X gives exactly X+1 enabled cycles with `den_o` high per line.
- R3: Each line is, in order: `lsync_o` high for `hsync_len_i`+1 enabled cycles, then `hback_len_i`+1 cycles with all outputs low, then `xfer_cnt_i`+1 cycles with `den_o` high, then `hfront_len_i`+1 cycles with all outputs low. The next line follows at once.
- R4: A frame has `line_cnt_i`+1 lines with no extra vertical lines. `fsync_o` is high exactly while `lsync_o` is high in line 0 of each frame.
- R5: With `ac_sel_i`=1, `ac_mode_o` inverts at the end of every (`ac_lines_i`+1)-th completed line, counted continuously across frames.
- R6: With `ac_sel_i`=0, `ac_mode_o` inverts once per frame, at the end of the frame's last line.
- R7: On a cycle with `pix_en` low, no counter advances and all outputs hold their values.
- R8: All configuration inputs are captured only at a frame start (the first start after reset and each wrap after the last line). Changes made during a frame affect only the next frame.
- R9: `ac_mode_o` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable; one enabled cycle is one pixel-clock period |
| hsync_len_i | input | HPW_W (6) | Line sync width minus one |
| hback_len_i | input | HBP_W (8) | Back porch minus one |
| hfront_len_i | input | HFP_W (8) | Front porch minus one |
| xfer_cnt_i | input | HOZ_W (11) | Data transfers per line minus one |
| line_cnt_i | input | LIN_W (11) | Lines per frame minus one |
| ac_sel_i | input | 1 | 1: AC bias by line count; 0: once per frame |
| ac_lines_i | input | MVAL_W (8) | Lines between AC-bias toggles minus one |
| lsync_o | output | 1 | Line sync |
| fsync_o | output | 1 | Frame sync |
| den_o | output | 1 | Data-transfer valid window |
| ac_mode_o | output | 1 | AC-bias (MODE) output |

## Verification
The outputs are decoded from registered state, so each result appears in the cycle after the clock edge on which `pix_en` was high. Configuration written before a frame-start edge governs the frame that begins on that edge. The bench keeps its own position in the frame as arithmetic over enabled cycles. It updates that position only for edges on which it drove `pix_en` high, and compares all four outputs at the following falling edge. Configuration changes are made at falling edges in mid-frame. The bench takes new lengths only when its own frame counter wraps, so the frame in progress is checked against the old lengths.

// File: rtl/stn_tim_pkg.sv
package stn_tim_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SYNC  = 3'd1,
    PH_BACK  = 3'd2,
    PH_ACT   = 3'd3,
    PH_FRONT = 3'd4
  } phase_e;
endpackage

// File: rtl/stn_cfg_shadow.sv
module stn_cfg_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (load) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= '0;
    else if (load) q_q <= q_d;
  end

  assign q = q_q;

  AST_SHADOW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q_q)); // R8
endmodule

// File: rtl/stn_hphase.sv
module stn_hphase
  import stn_tim_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_en,
  input  logic [CNT_W-1:0] sync_lim,
  input  logic [CNT_W-1:0] back_lim,
  input  logic [CNT_W-1:0] act_lim,
  input  logic [CNT_W-1:0] front_lim,
  output phase_e           phase_o,
  output logic             line_last_o
);
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             seg_done;

  always_comb begin
    case (ph_q)
      PH_SYNC:  lim = sync_lim;
      PH_BACK:  lim = back_lim;
      PH_ACT:   lim = act_lim;
      PH_FRONT: lim = front_lim;
      default:  lim = '0;
    endcase
  end

  assign seg_done = (cnt_q >= lim);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (ph_q == PH_IDLE) begin
      ph_d  = PH_SYNC;
      cnt_d = '0;
    end else if (seg_done) begin
      cnt_d = '0;
      case (ph_q)
        PH_SYNC:  ph_d = PH_BACK;
        PH_BACK:  ph_d = PH_ACT;
        PH_ACT:   ph_d = PH_FRONT;
        default:  ph_d = PH_SYNC;
      endcase
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (pix_en) begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase_o     = ph_q;
  assign line_last_o = (ph_q == PH_FRONT) && seg_done;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE) |-> (cnt_q <= lim)); // R3
  AST_HOLD_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(ph_q) && $stable(cnt_q))); // R7
  AST_NO_RETURN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_IDLE) |=> (ph_q != PH_IDLE)); // R1
endmodule

// File: rtl/stn_vline.sv
module stn_vline #(
  parameter int LIN_W  = 11,
  parameter int MVAL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_adv,
  input  logic [LIN_W-1:0]  last_line,
  input  logic              ac_sel,
  input  logic [MVAL_W-1:0] ac_lines,
  output logic [LIN_W-1:0]  line_o,
  output logic              frame_last_o,
  output logic              mode_o
);
  logic [LIN_W-1:0]  line_q, line_d;
  logic [MVAL_W-1:0] mcnt_q, mcnt_d;
  logic              mode_q, mode_d;
  logic              at_last;

  assign at_last = (line_q >= last_line);

  always_comb begin
    line_d = at_last ? '0 : line_q + 1'b1;
    mcnt_d = mcnt_q;
    mode_d = mode_q;
    if (ac_sel) begin
      if (mcnt_q >= ac_lines) begin
        mcnt_d = '0;
        mode_d = ~mode_q;
      end else begin
        mcnt_d = mcnt_q + 1'b1;
      end
    end else begin
      mcnt_d = '0;
      if (at_last) mode_d = ~mode_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      mcnt_q <= '0;
      mode_q <= 1'b0;
    end else if (line_adv) begin
      line_q <= line_d;
      mcnt_q <= mcnt_d;
      mode_q <= mode_d;
    end
  end

  assign line_o       = line_q;
  assign frame_last_o = at_last;
  assign mode_o       = mode_q;

  AST_LINE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    line_q <= last_line); // R4
  AST_MODE_ON_LINE_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(line_adv)); // R5
endmodule

// File: rtl/stn_line_timer.sv
module stn_line_timer
  import stn_tim_pkg::*;
#(
  parameter int HPW_W  = 6,
  parameter int HBP_W  = 8,
  parameter int HFP_W  = 8,
  parameter int HOZ_W  = 11,
  parameter int LIN_W  = 11,
  parameter int MVAL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_en,
  input  logic [HPW_W-1:0]  hsync_len_i,
  input  logic [HBP_W-1:0]  hback_len_i,
  input  logic [HFP_W-1:0]  hfront_len_i,
  input  logic [HOZ_W-1:0]  xfer_cnt_i,
  input  logic [LIN_W-1:0]  line_cnt_i,
  input  logic              ac_sel_i,
  input  logic [MVAL_W-1:0] ac_lines_i,
  output logic              lsync_o,
  output logic              fsync_o,
  output logic              den_o,
  output logic              ac_mode_o
);
  localparam int MAX_A = (HPW_W > HBP_W) ? HPW_W : HBP_W;
  localparam int MAX_B = (HFP_W > HOZ_W) ? HFP_W : HOZ_W;
  localparam int CNT_W = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int SH_W  = HPW_W + HBP_W + HFP_W + HOZ_W + LIN_W + 1 + MVAL_W;

  logic [SH_W-1:0]   sh_d, sh_q;
  logic [HPW_W-1:0]  s_hpw;
  logic [HBP_W-1:0]  s_hbp;
  logic [HFP_W-1:0]  s_hfp;
  logic [HOZ_W-1:0]  s_hoz;
  logic [LIN_W-1:0]  s_lin;
  logic              s_sel;
  logic [MVAL_W-1:0] s_mval;
  phase_e            phase;
  logic              line_last, frame_last, line_adv, frame_load;
  logic [LIN_W-1:0]  line;
  logic              mode;

  assign sh_d = {hsync_len_i, hback_len_i, hfront_len_i, xfer_cnt_i,
                 line_cnt_i, ac_sel_i, ac_lines_i};
  assign {s_hpw, s_hbp, s_hfp, s_hoz, s_lin, s_sel, s_mval} = sh_q;

  assign line_adv   = pix_en && line_last;
  assign frame_load = pix_en && ((phase == PH_IDLE) || (line_last && frame_last));

  stn_cfg_shadow #(.W(SH_W)) u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (frame_load),
    .d     (sh_d),
    .q     (sh_q)
  );

  stn_hphase #(.CNT_W(CNT_W)) u_hphase (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_en      (pix_en),
    .sync_lim    (CNT_W'(s_hpw)),
    .back_lim    (CNT_W'(s_hbp)),
    .act_lim     (CNT_W'(s_hoz)),
    .front_lim   (CNT_W'(s_hfp)),
    .phase_o     (phase),
    .line_last_o (line_last)
  );

  stn_vline #(.LIN_W(LIN_W), .MVAL_W(MVAL_W)) u_vline (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_adv     (line_adv),
    .last_line    (s_lin),
    .ac_sel       (s_sel),
    .ac_lines     (s_mval),
    .line_o       (line),
    .frame_last_o (frame_last),
    .mode_o       (mode)
  );

  assign lsync_o   = (phase == PH_SYNC);
  assign den_o     = (phase == PH_ACT);
  assign fsync_o   = (phase == PH_SYNC) && (line == '0);
  assign ac_mode_o = mode;

  AST_FRAME_START_AT_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> (line == '0)); // R4
  AST_DEN_AFTER_PORCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(den_o) |-> ($past(phase) == PH_BACK)); // R3
endmodule

// File: tb/stn_line_timer_tb.sv
module stn_line_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pix_en;
  logic [5:0]  hsync_len_i;
  logic [7:0]  hback_len_i;
  logic [7:0]  hfront_len_i;
  logic [10:0] xfer_cnt_i;
  logic [10:0] line_cnt_i;
  logic        ac_sel_i;
  logic [7:0]  ac_lines_i;
  logic        lsync_o, fsync_o, den_o, ac_mode_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  stn_line_timer u_dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .hsync_len_i(hsync_len_i), .hback_len_i(hback_len_i),
    .hfront_len_i(hfront_len_i), .xfer_cnt_i(xfer_cnt_i),
    .line_cnt_i(line_cnt_i), .ac_sel_i(ac_sel_i), .ac_lines_i(ac_lines_i),
    .lsync_o(lsync_o), .fsync_o(fsync_o), .den_o(den_o), .ac_mode_o(ac_mode_o)
  );

  // bench model state
  bit started, pend;
  int kf, bS, bB, bA, bL, bN, bF, bsel, bmv, mexp, mc;
  int c_hpw, c_hbp, c_hfp, c_hoz, c_lv, c_sel, c_mv;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_cfg();
    hsync_len_i  = 6'(c_hpw);
    hback_len_i  = 8'(c_hbp);
    hfront_len_i = 8'(c_hfp);
    xfer_cnt_i   = 11'(c_hoz);
    line_cnt_i   = 11'(c_lv);
    ac_sel_i     = c_sel[0];
    ac_lines_i   = 8'(c_mv);
  endtask

  task automatic latch();
    bS = c_hpw + 1; bB = c_hbp + 1; bA = c_hoz + 1;
    bL = bS + bB + bA + c_hfp + 1;
    bN = c_lv + 1; bF = bL * bN;
    bsel = c_sel; bmv = c_mv;
    kf = 0; pend = 0;
  endtask

  task automatic advance();
    if (!started) begin
      started = 1; latch();
    end else begin
      if ((kf % bL) == bL - 1) begin
        if (bsel != 0) begin
          if (mc >= bmv) begin mexp ^= 1; mc = 0; end
          else mc++;
        end else begin
          mc = 0;
          if (kf == bF - 1) mexp ^= 1;
        end
      end
      kf++;
      if (kf == bF) latch();
    end
  endtask

  task automatic run_cfg(input int idx, input int hpw, input int hbp, input int hfp,
                         input int hoz, input int lv);
    int fa, fb, ncyc, chg;
    bit pe;
    int p_ls, p_fs, p_de, p_md;
    c_hpw = hpw; c_hbp = hbp; c_hfp = hfp; c_hoz = hoz; c_lv = lv;
    c_sel = idx % 2; c_mv = idx % 3;
    @(negedge clk);
    rst_n = 1'b0; pix_en = 1'b1; drive_cfg();
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R1", {lsync_o, fsync_o, den_o, ac_mode_o}, 0);
    end
    started = 0; mexp = 0; mc = 0; pend = 0;
    fa = (hpw + hbp + hfp + hoz + 4) * (lv + 1);
    fb = (hpw + hbp + ((hfp + 2) % 3) + ((hoz + 1) % 4) + 4) * (((lv + 1) % 3) + 1);
    chg = fa / 2 + 1;
    ncyc = 3 * (fa + 2 * fb) + 10;
    pe = ((idx * 3) % 7) != 0;
    pix_en = pe; rst_n = 1'b1;
    p_ls = 0; p_fs = 0; p_de = 0; p_md = 0;
    for (int c = 0; c < ncyc; c++) begin
      bit was_started;
      int pos, ln, els, ede, efs;
      string rq;
      @(negedge clk);
      was_started = started;
      if (pe) advance();
      pos = kf % bL; ln = kf / bL;
      els = (started && pos < bS) ? 1 : 0;
      ede = (started && pos >= bS + bB && pos < bS + bB + bA) ? 1 : 0;
      efs = (els == 1 && ln == 0) ? 1 : 0;
      if (c == 0) chk("R9", ac_mode_o, 0);
      rq = pend ? "R8" : "R3";
      chk(rq, lsync_o, els);
      chk(pend ? "R8" : "R2", den_o, ede);
      chk("R4", fsync_o, efs);
      chk(bsel != 0 ? "R5" : "R6", ac_mode_o, mexp);
      if (!pe && was_started) begin
        chk("R7", {lsync_o, fsync_o, den_o, ac_mode_o},
            {p_ls[0], p_fs[0], p_de[0], p_md[0]});
      end
      p_ls = lsync_o; p_fs = fsync_o; p_de = den_o; p_md = ac_mode_o;
      if (c == chg) begin
        c_hfp = (hfp + 2) % 3; c_hoz = (hoz + 1) % 4; c_lv = (lv + 1) % 3;
        c_mv = (c_mv + 1) % 3;
        drive_cfg();
        pend = 1;
      end
      pe = ((c * 3 + idx) % 7) != 0;
      pix_en = pe;
    end
  endtask

  initial begin
    int idx;
    rst_n = 1'b0; pix_en = 1'b0;
    c_hpw = 0; c_hbp = 0; c_hfp = 0; c_hoz = 0; c_lv = 0; c_sel = 0; c_mv = 0;
    drive_cfg();
    idx = 0;
    for (int hpw = 0; hpw < 3; hpw++)
      for (int hbp = 0; hbp < 2; hbp++)
        for (int hfp = 0; hfp < 3; hfp++)
          for (int hoz = 0; hoz < 4; hoz++)
            for (int lv = 0; lv < 3; lv++) begin
              run_cfg(idx, hpw, hbp, hfp, hoz, lv);
              idx++;
            end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule